// File: doc/BRIEF.md
# Cyclic Tour Cost Accumulator

This block scores one candidate route for a travelling-salesman search. A route is a sequence of city indices held in a word-addressed tour store. Each 32-bit word carries four 7-bit indices. After a start pulse the block reads the route one word at a time and unpacks the four cities. For every adjacent pair of cities it looks up the edge cost in a distance table. The table holds only the strictly lower triangle of the symmetric cost matrix and is replicated behind four independent read ports, so the block can fetch all four edge costs of a word in the same cycle. The edge that joins the last city of one word to the first city of the next is carried across the word boundary. After the last word, the edge from the final city back to the first city closes the cycle. The total is a saturating sum, and a smaller value marks a better route.

The control is a single state machine: `S_IDLE` waits for `start`. `S_READ` issues a tour read. In `S_LOOKUP` the returned word is unpacked and up to four cost reads are issued. In `S_GATHER` the returned costs are added. From `S_GATHER` the machine goes back to `S_READ` while words remain, or moves to `S_WRAP` after the last word. `S_WRAP` issues the closing-edge lookup and `S_WRAPSUM` adds it. `S_REPORT` raises `result_valid` for one cycle and returns to `S_IDLE`. Both memories answer one cycle after a read request. A route of N cities takes 3·ceil(N/4)+3 cycles from the start pulse to the valid pulse. N of 0 still uses one word.

Top module: `tour_cost_acc`

## Requirements
- R1: When `result_valid` is high, `result` equals the sum of d(c[k], c[(k+1) mod N]) for k = 0..N-1. This includes the closing edge from the last city back to the first. When N = 2 the single edge is counted twice.
- R2: The cost of a pair (i, j) with i ≠ j is read at table address hi·(hi−1)/2 + lo, where hi = max(i,j) and lo = min(i,j). The cost is therefore the same in either direction, and every issued address lies below N_max·(N_max−1)/2.
- R3: City k of a tour word (k = 0..3) is taken from bits 8k+6 down to 8k, and city k of word w is route position 4w+k. Bits 7, 15, 23 and 31 are ignored.
- R4: When N is not a multiple of four, the lanes of the last word at positions N and above add nothing and do not affect the closing edge.
- R5: The 24-bit total saturates at 2^24−1 instead of wrapping. While a run is in progress, `result` never decreases.
- R6: A pair whose two cities are equal adds zero and issues no cost read. As a result, N = 0 and N = 1 give a total of 0.
- R7: `result_valid` is a single-cycle pulse. In the cycle after it, both `result_valid` and `busy` are low.
- R8: A `start` pulse that arrives while `busy` is high is ignored. `node_count` is sampled only on the accepted start.
- R9: A `node_count` above 128 is treated as 128.
- R10: A tour read and cost reads are never issued in the same cycle. After reset, `busy`, `result_valid`, `result`, `tour_rd` and `dist_rd` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin scoring a route (accepted only when idle) |
| node_count | input | 8 | Number of cities N in the route |
| tour_rd | output | 1 | Tour store read request |
| tour_addr | output | 5 | Tour word index |
| tour_data | input | 32 | Tour word, returned one cycle after `tour_rd` |
| dist_rd | output | 4 | Per-port cost read request |
| dist_addr | output | 52 | Four 13-bit triangular addresses, port k in bits 13k+12:13k |
| dist_data | input | 80 | Four 20-bit costs, port k in bits 20k+19:20k, returned one cycle after the request |
| busy | output | 1 | A run is in progress |
| result_valid | output | 1 | One-cycle pulse marking a finished total |
| result | output | 24 | Saturating route cost, held until the next accepted start |

## Verification
The assertions assume that both memories answer exactly one cycle after a request. They also assume that the cost table returns the same value whichever replica is read. The bench models the stores so that these hold: every replica computes its cost from the address alone, and the tour store returns its word on the next edge. The address-range check further assumes that only indices below 128 reach the address calculator. Since the index fields are seven bits wide, no stimulus can violate this.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_LOOKUP,
        S_GATHER,
        S_WRAP,
        S_WRAPSUM,
        S_REPORT
    } tcs_state_t;
endpackage

// File: rtl/tcs_unpack.sv
module tcs_unpack #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int CITY_W = 7
) (
    input  logic [WORD_W-1:0]              word,
    output logic [LANES-1:0][CITY_W-1:0]   city
);
    localparam int LANE_W = WORD_W / LANES;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // Only the low CITY_W bits of each byte-wide field carry the index.
        assign city[j] = word[j*LANE_W +: CITY_W];
    end
endmodule

// File: rtl/tcs_pair_addr.sv
module tcs_pair_addr #(
    parameter int CITY_W  = 7,
    parameter int TADDR_W = 13
) (
    input  logic [CITY_W-1:0]  a,
    input  logic [CITY_W-1:0]  b,
    output logic [TADDR_W-1:0] addr,
    output logic               same
);
    localparam int PROD_W = 2 * CITY_W;

    logic [CITY_W-1:0] hi, lo;
    logic [PROD_W-1:0] prod;

    always_comb begin
        hi   = (a > b) ? a : b;
        lo   = (a > b) ? b : a;
        prod = PROD_W'(hi) * (PROD_W'(hi) - PROD_W'(1));
        addr = TADDR_W'((prod >> 1) + PROD_W'(lo));
        same = (a == b);
    end
endmodule

// File: rtl/tcs_lane_sum.sv
module tcs_lane_sum #(
    parameter int LANES  = 4,
    parameter int DIST_W = 20,
    parameter int ACC_W  = 24
) (
    input  logic [ACC_W-1:0]             acc,
    input  logic [LANES-1:0][DIST_W-1:0] cost,
    input  logic [LANES-1:0]             live,
    output logic [ACC_W-1:0]             acc_next
);
    localparam int SUM_W  = DIST_W + $clog2(LANES);
    localparam int WIDE_W = ACC_W + 1;

    logic [SUM_W-1:0]  total;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        total = '0;
        for (int j = 0; j < LANES; j++) begin
            if (live[j]) total = total + SUM_W'(cost[j]);
        end
        wide     = WIDE_W'(acc) + WIDE_W'(total);
        acc_next = wide[ACC_W] ? '1 : wide[ACC_W-1:0];
    end
endmodule

// File: rtl/tour_cost_acc.sv
module tour_cost_acc
    import tcs_pkg::*;
#(
    parameter int CITY_W    = 7,
    parameter int LANES     = 4,
    parameter int WORD_W    = 32,
    parameter int MAX_NODES = 128,
    parameter int DIST_W    = 20,
    parameter int ACC_W     = 24,
    localparam int PAIR_CNT = MAX_NODES * (MAX_NODES - 1) / 2,
    localparam int TADDR_W  = $clog2(PAIR_CNT),
    localparam int NCNT_W   = $clog2(MAX_NODES + 1),
    localparam int WADDR_W  = $clog2((MAX_NODES + LANES - 1) / LANES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NCNT_W-1:0]         node_count,
    output logic                      tour_rd,
    output logic [WADDR_W-1:0]        tour_addr,
    input  logic [WORD_W-1:0]         tour_data,
    output logic [LANES-1:0]          dist_rd,
    output logic [LANES*TADDR_W-1:0]  dist_addr,
    input  logic [LANES*DIST_W-1:0]   dist_data,
    output logic                      busy,
    output logic                      result_valid,
    output logic [ACC_W-1:0]          result
);
    localparam int IDX_W = NCNT_W + 1;
    localparam int LSH   = $clog2(LANES);

    tcs_state_t state_q, state_d;

    logic [NCNT_W-1:0]  n_q, n_clamp;
    logic [WADDR_W-1:0] word_q, wlast_q;
    logic [CITY_W-1:0]  first_q, last_q;
    logic [ACC_W-1:0]   acc_q, acc_next;
    logic [LANES-1:0]   live_q, edge_ok, node_ok, same;
    logic               in_lookup, in_wrap;

    logic [LANES-1:0][CITY_W-1:0]  city;
    logic [LANES-1:0][DIST_W-1:0]  cost;
    logic [CITY_W-1:0]             pa   [LANES];
    logic [CITY_W-1:0]             pb   [LANES];
    logic [TADDR_W-1:0]            addr [LANES];

    assign in_lookup = (state_q == S_LOOKUP);
    assign in_wrap   = (state_q == S_WRAP);
    assign n_clamp   = (node_count > NCNT_W'(MAX_NODES)) ? NCNT_W'(MAX_NODES) : node_count;

    tcs_unpack #(.WORD_W(WORD_W), .LANES(LANES), .CITY_W(CITY_W)) u_unpack (
        .word (tour_data),
        .city (city)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_edge
        logic [IDX_W-1:0] pos;
        assign pos        = (IDX_W'(word_q) << LSH) + IDX_W'(j);
        assign node_ok[j] = in_lookup && (pos < IDX_W'(n_q));

        if (j == 0) begin : g_carry
            // Lane 0 pairs the city carried from the previous word, or closes the cycle.
            assign pa[j]      = last_q;
            assign pb[j]      = in_wrap ? first_q : city[0];
            assign edge_ok[j] = (node_ok[j] && (word_q != '0) && !same[j]) ||
                                (in_wrap && !same[j]);
        end else begin : g_inner
            assign pa[j]      = city[j-1];
            assign pb[j]      = city[j];
            assign edge_ok[j] = node_ok[j] && !same[j];
        end

        tcs_pair_addr #(.CITY_W(CITY_W), .TADDR_W(TADDR_W)) u_pair (
            .a    (pa[j]),
            .b    (pb[j]),
            .addr (addr[j]),
            .same (same[j])
        );

        assign dist_addr[j*TADDR_W +: TADDR_W] = addr[j];
        assign cost[j] = dist_data[j*DIST_W +: DIST_W];
    end

    tcs_lane_sum #(.LANES(LANES), .DIST_W(DIST_W), .ACC_W(ACC_W)) u_sum (
        .acc      (acc_q),
        .cost     (cost),
        .live     (live_q),
        .acc_next (acc_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_READ;
            S_READ:    state_d = S_LOOKUP;
            S_LOOKUP:  state_d = S_GATHER;
            S_GATHER:  state_d = (word_q == wlast_q) ? S_WRAP : S_READ;
            S_WRAP:    state_d = S_WRAPSUM;
            S_WRAPSUM: state_d = S_REPORT;
            S_REPORT:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q     <= '0;
            word_q  <= '0;
            wlast_q <= '0;
            first_q <= '0;
            last_q  <= '0;
            live_q  <= '0;
            acc_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        n_q     <= n_clamp;
                        word_q  <= '0;
                        wlast_q <= (n_clamp == '0) ? '0 : WADDR_W'((n_clamp - NCNT_W'(1)) >> LSH);
                        acc_q   <= '0;
                    end
                end
                S_LOOKUP: begin
                    live_q <= edge_ok;
                    if (word_q == '0) begin
                        first_q <= city[0];
                        last_q  <= city[0];
                    end
                    for (int j = 0; j < LANES; j++) begin
                        if (node_ok[j]) last_q <= city[j];
                    end
                end
                S_GATHER: begin
                    acc_q <= acc_next;
                    if (word_q != wlast_q) word_q <= word_q + WADDR_W'(1);
                end
                S_WRAP:    live_q <= edge_ok;
                S_WRAPSUM: acc_q  <= acc_next;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tour_rd      = 1'b0;
        dist_rd      = '0;
        busy         = 1'b1;
        result_valid = 1'b0;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_READ:   tour_rd = 1'b1;
            S_LOOKUP: dist_rd = edge_ok;
            S_WRAP:   dist_rd = edge_ok;
            S_REPORT: result_valid = 1'b1;
            default: ;
        endcase
        tour_addr = word_q;
        result    = acc_q;
    end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
    parameter int LANES    = 4,
    parameter int TADDR_W  = 13,
    parameter int PAIR_CNT = 8128,
    parameter int ACC_W    = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     busy,
    input logic                     result_valid,
    input logic [ACC_W-1:0]         result,
    input logic                     tour_rd,
    input logic [LANES-1:0]         dist_rd,
    input logic [LANES*TADDR_W-1:0] dist_addr
);
    for (genvar k = 0; k < LANES; k++) begin : g_port
        assert_addr_in_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
            dist_rd[k] |-> (dist_addr[k*TADDR_W +: TADDR_W] < TADDR_W'(PAIR_CNT)));
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (result >= $past(result)));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> (!result_valid && !busy));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !result_valid && start) |=> busy);

    assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tour_rd && (|dist_rd)));
endmodule

bind tour_cost_acc tcs_checker #(
    .LANES    (LANES),
    .TADDR_W  (TADDR_W),
    .PAIR_CNT (PAIR_CNT),
    .ACC_W    (ACC_W)
) u_tcs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .result_valid (result_valid),
    .result       (result),
    .tour_rd      (tour_rd),
    .dist_rd      (dist_rd),
    .dist_addr    (dist_addr)
);

// File: tb/test_tour_cost_acc.sv
module test_tour_cost_acc;
    localparam int LANES   = 4;
    localparam int TADDR_W = 13;
    localparam int DIST_W  = 20;
    localparam int ACC_W   = 24;
    localparam int MAXN    = 128;
    localparam int WORDS   = 32;
    localparam longint SAT = (64'd1 << ACC_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] node_count = '0;
    logic tour_rd;
    logic [4:0] tour_addr;
    logic [31:0] tour_data;
    logic [LANES-1:0] dist_rd;
    logic [LANES*TADDR_W-1:0] dist_addr;
    logic [LANES*DIST_W-1:0] dist_data;
    logic busy, result_valid;
    logic [ACC_W-1:0] result;

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit maxmode = 0;
    bit junk = 0;
    logic [6:0]  cities   [MAXN];
    logic [31:0] tour_mem [WORDS];

    tour_cost_acc i_tour_cost_acc (
        .clk(clk), .rst_n(rst_n), .start(start), .node_count(node_count),
        .tour_rd(tour_rd), .tour_addr(tour_addr), .tour_data(tour_data),
        .dist_rd(dist_rd), .dist_addr(dist_addr), .dist_data(dist_data),
        .busy(busy), .result_valid(result_valid), .result(result)
    );

    function automatic int tri_idx(int a, int b);
        int hi = (a > b) ? a : b;
        int lo = (a > b) ? b : a;
        return hi * (hi - 1) / 2 + lo;
    endfunction

    function automatic longint dval(int addr);
        if (maxmode) return (64'd1 << DIST_W) - 1;
        return ((addr * 97 + 13) % 1000) + 1;
    endfunction

    function automatic longint expect_cost(int n);
        longint s = 0;
        if (n < 2) return 0;
        for (int k = 0; k < n; k++) begin
            int a = cities[k];
            int b = cities[(k + 1) % n];
            if (a != b) s += dval(tri_idx(a, b));
        end
        return (s > SAT) ? SAT : s;
    endfunction

    // Tour store: one-cycle read latency
    logic [31:0] tour_q = '0;
    always @(posedge clk) if (tour_rd) tour_q <= tour_mem[tour_addr];
    assign tour_data = tour_q;

    // Four replicated cost tables, each a pure function of its address
    for (genvar k = 0; k < LANES; k++) begin : g_tab
        logic [DIST_W-1:0] q = '0;
        always @(posedge clk)
            if (dist_rd[k]) q <= DIST_W'(dval(int'(dist_addr[k*TADDR_W +: TADDR_W])));
        assign dist_data[k*DIST_W +: DIST_W] = q;
    end

    task automatic load_tour();
        for (int w = 0; w < WORDS; w++) begin
            logic [31:0] word = '0;
            for (int j = 0; j < LANES; j++) begin
                word[8*j +: 7] = cities[4*w + j];
                if (junk) word[8*j + 7] = 1'b1;
            end
            tour_mem[w] = word;
        end
    endtask

    task automatic fill(int seed);
        for (int k = 0; k < MAXN; k++)
            cities[k] = 7'((k * seed * 29 + seed * 11 + k * k * 3) % 128);
    endtask

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(int n, int exp_n, string req, bit poke);
        longint exp;
        int guard = 0;
        load_tour();
        exp = expect_cost(exp_n);
        @(negedge clk);
        node_count = 8'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            node_count = 8'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!result_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(result_valid == 1'b1, {req, " valid seen"}, result_valid, 1);
        check(longint'(result) == exp, req, result, exp);
        @(negedge clk);
        check(!result_valid && !busy, "R7 pulse ends", {result_valid, busy}, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < MAXN; k++) cities[k] = '0;
        load_tour();
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy && !result_valid && result == '0 && !tour_rd && dist_rd == '0,
              "R10 reset", {busy, result_valid, tour_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && result == '0, "R10 idle after reset", busy, 0);

        // R1 R3 R4: sweep of route lengths, odd lengths carry set filler bits
        for (int n = 2; n <= 40; n++) begin
            fill(n + 3);
            junk = n[0];
            run(n, n, "R1 R3 R4 sweep", 0);
        end
        junk = 0;

        // R6: degenerate routes
        fill(5);
        run(0, 0, "R6 empty route", 0);
        run(1, 1, "R6 single city", 0);
        for (int k = 0; k < MAXN; k++) cities[k] = 7'd42;
        run(9, 9, "R6 repeated city", 0);

        // R1: two cities counts the edge twice
        fill(7);
        cities[0] = 7'd100; cities[1] = 7'd3;
        run(2, 2, "R1 two cities", 0);
        check(longint'(result) == 2 * dval(tri_idx(100, 3)), "R2 pair address", result,
              2 * dval(tri_idx(100, 3)));

        // R2: full-size route reaching the top of the table
        for (int k = 0; k < MAXN; k++) cities[k] = 7'(127 - k);
        run(128, 128, "R2 full route", 0);

        // R9: oversized count clamps
        fill(9);
        junk = 1;
        run(200, 128, "R9 clamp", 0);
        junk = 0;

        // R8: start during a run is ignored
        fill(11);
        run(37, 37, "R8 start while busy", 1);

        // R5: saturation boundary
        maxmode = 1;
        for (int k = 0; k < MAXN; k++) cities[k] = 7'(k);
        run(16, 16, "R5 just below limit", 0);
        run(17, 17, "R5 saturate", 0);
        run(128, 128, "R5 saturate full", 0);
        maxmode = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule